// File: doc/BRIEF.md
# Dedicated Address Register Unit

This unit keeps the three dedicated address registers of a 16-bit processor core: a 24-bit program counter, a 32-bit interrupt stack pointer and a 32-bit user stack pointer. The hard-wired zero bits of each register are enforced on every write, whether that write is a direct load, a program counter advance or a stack adjustment.

The execute stage drives the unit. It loads or advances the program counter, writes either stack pointer directly, and issues push or pop requests of 2 or 4 bytes. A user-mode status bit routes each push or pop to one of the two stack pointers and also picks which pointer appears on the active stack pointer output. Both stacks grow downward, so a push subtracts and a pop adds.

A stack access through a user stack pointer that holds an address wider than 24 bits does not move the pointer. It raises a one-cycle illegal-address trap strobe instead. An asynchronous cold reset clears the unit. A synchronous warm reset returns the program counter to its preset value and exposes the value it held before, so the exception logic can save it.

Top module: `dar_unit`

## Requirements
- R1: The program counter is PC_W (24) bits wide and its bit 0 always reads 0: a load of pc_load_val_i stores the value with bit 0 cleared.
- R2: While rst_ni is low, pc_o equals PC_RESET_VAL with bit 0 cleared, and isp_o, usp_o, saved_pc_o and trap_o are all 0.
- R3: A clock edge with warm_rst_i high copies the prior pc_o into saved_pc_o and reloads pc_o with the reset value. It leaves both stack pointers unchanged and takes priority over a load or an advance in the same cycle. saved_pc_o holds its value until the next warm reset.
- R4: With pc_adv_i high, pc_o advances by pc_adv_bytes_i with that input's bit 0 ignored, modulo 2^24. A load in the same cycle takes priority over the advance.
- R5: isp_o bit 0 and bits 31:24 always read 0. A write through isp_wr_i stores sp_wr_val_i with those bits cleared.
- R6: push_i lowers the selected stack pointer by 2 when size4_i=0 and by 4 when size4_i=1, and pop_i raises it by the same amount. If both are high, the push wins. The interrupt stack pointer result is masked as in R5, and the user stack pointer wraps modulo 2^32. A direct write to a pointer in the same cycle overrides the push or pop on that pointer.
- R7: When user_mode_i=1, pushes and pops act on the user stack pointer and sp_o shows usp_o. When user_mode_i=0, they act on the interrupt stack pointer and sp_o shows isp_o. The pointer that is not selected is unchanged.
- R8: A push or pop with user_mode_i=1 while usp_o exceeds 0x00FF_FFFF (any of bits 31:24 set) makes trap_o high for exactly the following cycle. usp_o is then not adjusted.
- R9: trap_o stays low in every other case, including supervisor-mode stack accesses while usp_o is out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low cold reset |
| warm_rst_i | input | 1 | Synchronous warm reset |
| pc_load_i | input | 1 | Load program counter |
| pc_load_val_i | input | 24 | Program counter load value |
| pc_adv_i | input | 1 | Advance program counter |
| pc_adv_bytes_i | input | 4 | Advance byte count (bit 0 ignored) |
| isp_wr_i | input | 1 | Write interrupt stack pointer |
| usp_wr_i | input | 1 | Write user stack pointer |
| sp_wr_val_i | input | 32 | Stack pointer write value |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| size4_i | input | 1 | Access size: 0 = 2 bytes, 1 = 4 bytes |
| user_mode_i | input | 1 | User-mode status bit, selects the stack pointer |
| pc_o | output | 24 | Program counter |
| saved_pc_o | output | 24 | Program counter captured at the last warm reset |
| isp_o | output | 32 | Interrupt stack pointer |
| usp_o | output | 32 | User stack pointer |
| sp_o | output | 32 | Active stack pointer |
| trap_o | output | 1 | Illegal-address trap strobe |

## Verification
The bench sweeps every advance count from a program counter near the top of its range. A design that honoured bit 0 of the count or of a load value would leave an odd PC, and one with the wrong width would fail to wrap. It pushes from an interrupt stack pointer of zero and expects 0x00FF_FFFE, because a missing mask would expose the upper byte. It pops a user pointer from 0x00FF_FFFE to 0x0100_0000 and then pushes, which must trap without moving the pointer. A design that checked the post-update value, or trapped in supervisor mode, would strobe at the wrong time. Warm reset issued together with a load, and push issued together with pop, test the priority orders: a design that got either order wrong would leave a different register value.

// File: rtl/dar_pkg.sv
package dar_pkg;
  typedef enum logic [1:0] {
    SOP_NONE = 2'd0,
    SOP_PUSH = 2'd1,
    SOP_POP  = 2'd2
  } stack_op_e;
endpackage

// File: rtl/dar_pc_reg.sv
module dar_pc_reg #(
  parameter int unsigned PC_W = 24,
  parameter int unsigned ADV_W = 4,
  parameter logic [PC_W-1:0] PC_RESET_VAL = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            warm_rst_i,
  input  logic            load_i,
  input  logic [PC_W-1:0] load_val_i,
  input  logic            adv_i,
  input  logic [ADV_W-1:0] adv_bytes_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] saved_pc_o
);
  localparam logic [PC_W-1:0] RST_PC = PC_RESET_VAL & ~PC_W'(1);

  logic [PC_W-1:0]  pc_q, saved_q;
  logic [ADV_W-1:0] adv_even;

  assign adv_even = adv_bytes_i & ~ADV_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= RST_PC;
      saved_q <= '0;
    end else if (warm_rst_i) begin
      saved_q <= pc_q;
      pc_q    <= RST_PC;
    end else if (load_i) begin
      pc_q <= load_val_i & ~PC_W'(1);
    end else if (adv_i) begin
      pc_q <= pc_q + PC_W'(adv_even);
    end
  end

  assign pc_o       = pc_q;
  assign saved_pc_o = saved_q;

  AST_WARM_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_i |=> (saved_pc_o == $past(pc_o)) && (pc_o == RST_PC)); // R3
  AST_PC_LOAD_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !warm_rst_i) |=> (pc_o[0] == 1'b0) &&
      (pc_o[PC_W-1:1] == $past(load_val_i[PC_W-1:1]))); // R1
  AST_PC_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && !warm_rst_i) |=>
      (pc_o - $past(pc_o)) == PC_W'({$past(adv_bytes_i[ADV_W-1:1]), 1'b0})); // R4
endmodule

// File: rtl/dar_sp_reg.sv
module dar_sp_reg
  import dar_pkg::*;
#(
  parameter int unsigned SP_W = 32,
  parameter logic [SP_W-1:0] KEEP_MASK = '1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [SP_W-1:0] wr_val_i,
  input  stack_op_e       op_i,
  input  logic            size4_i,
  output logic [SP_W-1:0] sp_o
);
  logic [SP_W-1:0] sp_q, step, sp_d;

  assign step = size4_i ? SP_W'(4) : SP_W'(2);

  always_comb begin
    sp_d = sp_q;
    if (wr_i) sp_d = wr_val_i;
    else begin
      case (op_i)
        SOP_PUSH: sp_d = sp_q - step;
        SOP_POP:  sp_d = sp_q + step;
        default:  sp_d = sp_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sp_q <= '0;
    else         sp_q <= sp_d & KEEP_MASK;
  end

  assign sp_o = sp_q;

  AST_SP_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && op_i == SOP_NONE) |=> $stable(sp_o)); // R7
endmodule

// File: rtl/dar_unit.sv
module dar_unit
  import dar_pkg::*;
#(
  parameter int unsigned PC_W = 24,
  parameter int unsigned SP_W = 32,
  parameter int unsigned SP_LEGAL_W = 24,
  parameter int unsigned ADV_W = 4,
  parameter logic [PC_W-1:0] PC_RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             warm_rst_i,
  input  logic             pc_load_i,
  input  logic [PC_W-1:0]  pc_load_val_i,
  input  logic             pc_adv_i,
  input  logic [ADV_W-1:0] pc_adv_bytes_i,
  input  logic             isp_wr_i,
  input  logic             usp_wr_i,
  input  logic [SP_W-1:0]  sp_wr_val_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             size4_i,
  input  logic             user_mode_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [PC_W-1:0]  saved_pc_o,
  output logic [SP_W-1:0]  isp_o,
  output logic [SP_W-1:0]  usp_o,
  output logic [SP_W-1:0]  sp_o,
  output logic             trap_o
);
  localparam int unsigned HI_W = SP_W - SP_LEGAL_W;
  localparam logic [SP_W-1:0] ISP_KEEP = {{HI_W{1'b0}}, {(SP_LEGAL_W-1){1'b1}}, 1'b0};
  localparam logic [SP_W-1:0] USP_KEEP = '1;

  stack_op_e req_op, isp_op, usp_op;
  logic      usp_bad, stk_req, trap_q;

  dar_pc_reg #(
    .PC_W(PC_W), .ADV_W(ADV_W), .PC_RESET_VAL(PC_RESET_VAL)
  ) u_pc (
    .clk_i, .rst_ni, .warm_rst_i,
    .load_i(pc_load_i), .load_val_i(pc_load_val_i),
    .adv_i(pc_adv_i), .adv_bytes_i(pc_adv_bytes_i),
    .pc_o, .saved_pc_o
  );

  assign stk_req = push_i | pop_i;
  assign req_op  = push_i ? SOP_PUSH : (pop_i ? SOP_POP : SOP_NONE);
  assign usp_bad = |usp_o[SP_W-1:SP_LEGAL_W];
  assign isp_op  = user_mode_i ? SOP_NONE : req_op;
  assign usp_op  = (user_mode_i && !usp_bad) ? req_op : SOP_NONE;

  dar_sp_reg #(.SP_W(SP_W), .KEEP_MASK(ISP_KEEP)) u_isp (
    .clk_i, .rst_ni, .wr_i(isp_wr_i), .wr_val_i(sp_wr_val_i),
    .op_i(isp_op), .size4_i, .sp_o(isp_o)
  );

  dar_sp_reg #(.SP_W(SP_W), .KEEP_MASK(USP_KEEP)) u_usp (
    .clk_i, .rst_ni, .wr_i(usp_wr_i), .wr_val_i(sp_wr_val_i),
    .op_i(usp_op), .size4_i, .sp_o(usp_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trap_q <= 1'b0;
    else         trap_q <= user_mode_i && stk_req && usp_bad;
  end

  assign trap_o = trap_q;
  assign sp_o   = user_mode_i ? usp_o : isp_o;

  AST_ISP_ZERO_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isp_o[0] == 1'b0) && (isp_o[SP_W-1:SP_LEGAL_W] == '0)); // R5
  AST_TRAP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(user_mode_i && stk_req)); // R9
  AST_TRAP_NO_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && !$past(usp_wr_i)) |-> (usp_o == $past(usp_o))); // R8
  AST_USER_ISP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (user_mode_i && !isp_wr_i) |=> $stable(isp_o)); // R7
  AST_USP_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (user_mode_i && push_i && !usp_wr_i && !usp_bad) |=>
      ($past(usp_o) - usp_o) == ($past(size4_i) ? SP_W'(4) : SP_W'(2))); // R6
endmodule

// File: tb/dar_unit_tb.sv
module dar_unit_tb;
  localparam logic [23:0] PRESET = 24'h000101;
  localparam logic [23:0] RST_PC = 24'h000100;
  localparam logic [31:0] ISPM   = 32'h00FF_FFFE;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic warm, pld, padv, iwr, uwr, push, pop, sz4, um;
  logic [23:0] pval;
  logic [3:0]  pbytes;
  logic [31:0] wval;
  logic [23:0] pc, saved;
  logic [31:0] isp, usp, sp;
  logic        trap;

  logic [23:0] e_pc, e_saved;
  logic [31:0] e_isp, e_usp;
  logic        e_trap;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dar_unit #(.PC_RESET_VAL(PRESET)) u_dut (
    .clk_i(clk), .rst_ni, .warm_rst_i(warm), .pc_load_i(pld), .pc_load_val_i(pval),
    .pc_adv_i(padv), .pc_adv_bytes_i(pbytes), .isp_wr_i(iwr), .usp_wr_i(uwr),
    .sp_wr_val_i(wval), .push_i(push), .pop_i(pop), .size4_i(sz4), .user_mode_i(um),
    .pc_o(pc), .saved_pc_o(saved), .isp_o(isp), .usp_o(usp), .sp_o(sp), .trap_o(trap)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "pc", 32'(pc), 32'(e_pc));
    chk(tag, "saved_pc", 32'(saved), 32'(e_saved));
    chk(tag, "isp", isp, e_isp);
    chk(tag, "usp", usp, e_usp);
    chk(tag, "sp", sp, um ? e_usp : e_isp);
    chk(tag, "trap", 32'(trap), 32'(e_trap));
  endtask

  task automatic clr();
    @(negedge clk);
    {warm, pld, padv, iwr, uwr, push, pop, sz4, um} = '0;
    pval = '0; pbytes = '0; wval = '0;
  endtask

  task automatic tick(input string tag);
    logic [23:0] n_pc, n_saved;
    logic [31:0] n_isp, n_usp, step;
    logic        bad;
    n_pc = e_pc; n_saved = e_saved; n_isp = e_isp; n_usp = e_usp;
    step = sz4 ? 32'd4 : 32'd2;
    bad  = (e_usp > 32'h00FF_FFFF);
    if (warm) begin n_saved = e_pc; n_pc = RST_PC; end
    else if (pld) n_pc = {pval[23:1], 1'b0};
    else if (padv) n_pc = e_pc + 24'({pbytes[3:1], 1'b0});
    if (iwr) n_isp = wval & ISPM;
    else if (!um && (push || pop)) n_isp = (push ? e_isp - step : e_isp + step) & ISPM;
    if (uwr) n_usp = wval;
    else if (um && (push || pop) && !bad) n_usp = push ? e_usp - step : e_usp + step;
    @(posedge clk);
    #1;
    e_pc = n_pc; e_saved = n_saved; e_isp = n_isp; e_usp = n_usp;
    e_trap = um && (push || pop) && bad;
    chk_all(tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    {warm, pld, padv, iwr, uwr, push, pop, sz4, um} = '0;
    pval = '0; pbytes = '0; wval = '0;
    e_pc = RST_PC; e_saved = '0; e_isp = '0; e_usp = '0; e_trap = 1'b0;
    repeat (2) @(negedge clk);
    chk_all("R2");
    rst_ni = 1'b1;

    // R1: loads with bit 0 set
    foreach (pval_set[i]) begin
      clr(); pld = 1'b1; pval = pval_set[i]; tick("R1");
    end
    // R4: every advance count from near the top
    clr(); pld = 1'b1; pval = 24'hFFFFF0; tick("R1");
    for (int b = 0; b < 16; b++) begin
      clr(); padv = 1'b1; pbytes = 4'(b); tick("R4");
    end
    clr(); pld = 1'b1; padv = 1'b1; pval = 24'h00ABC2; pbytes = 4'd6; tick("R4");
    // R3: warm reset beats load, then saved value is held
    clr(); warm = 1'b1; pld = 1'b1; pval = 24'h777776; iwr = 1'b1; wval = 32'h40; tick("R3");
    clr(); padv = 1'b1; pbytes = 4'd8; tick("R3");
    clr(); warm = 1'b1; tick("R3");
    // R5: interrupt stack pointer masking
    clr(); iwr = 1'b1; wval = 32'hFFFF_FFFF; tick("R5");
    clr(); iwr = 1'b1; wval = 32'h1234_5679; tick("R5");
    // R6: supervisor push/pop sweep
    clr(); iwr = 1'b1; wval = 32'h100; tick("R6");
    for (int k = 0; k < 8; k++) begin
      clr(); sz4 = k[0]; push = !k[1]; pop = k[1]; tick("R6");
    end
    clr(); push = 1'b1; pop = 1'b1; sz4 = 1'b1; tick("R6");
    clr(); iwr = 1'b1; wval = 32'h0; tick("R6");
    clr(); push = 1'b1; tick("R6");
    clr(); iwr = 1'b1; push = 1'b1; wval = 32'h80; tick("R6");
    // R7: user mode uses user stack, interrupt stack untouched
    clr(); um = 1'b1; uwr = 1'b1; wval = 32'h00FF_FFFE; tick("R7");
    clr(); um = 1'b1; push = 1'b1; sz4 = 1'b1; tick("R7");
    clr(); um = 1'b1; pop = 1'b1; sz4 = 1'b1; tick("R7");
    clr(); um = 1'b1; pop = 1'b1; tick("R6");
    // R8: out-of-range user stack traps, pointer held
    clr(); um = 1'b1; push = 1'b1; sz4 = 1'b1; tick("R8");
    clr(); um = 1'b1; tick("R9");
    clr(); um = 1'b1; pop = 1'b1; tick("R8");
    clr(); push = 1'b1; tick("R9");
    clr(); um = 1'b1; uwr = 1'b1; wval = 32'hFFFF_FFFC; tick("R9");
    clr(); um = 1'b1; push = 1'b1; tick("R8");
    clr(); um = 1'b1; uwr = 1'b1; wval = 32'h0; tick("R9");
    clr(); um = 1'b1; push = 1'b1; tick("R6");
    clr(); tick("R9");
    // R2: cold reset mid-run
    clr(); rst_ni = 1'b0;
    #1;
    e_pc = RST_PC; e_saved = '0; e_isp = '0; e_usp = '0; e_trap = 1'b0;
    chk_all("R2");
    clr(); rst_ni = 1'b1;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  logic [23:0] pval_set [4] = '{24'hABCDEF, 24'h000001, 24'hFFFFFF, 24'h123456};
endmodule